// File: doc/BRIEF.md
# Buffered PWM Channel with Left/Center Alignment

This block is one pulse-width modulation channel. It advances an up counter on each pulse of a channel clock enable, compares the count against a duty value, and drives one output. Two alignment modes are available. In edge-aligned mode the count rises and then wraps. In center-aligned mode the count rises and then falls, so the active pulse sits symmetrically in the period. A polarity input sets whether the active part of each period is driven high or low.

Software-facing values arrive over simple write strobes. Period and duty are written into holding registers. The working copies used by the counter and the comparator take new values only at a period boundary, on a counter write, or while the channel is disabled, so a period is never cut short or stretched by a write. Writing the counter restarts the sequence from zero.

Top module: `pwm_chan_core`

## Requirements
- R1: After reset the count reads 0, the working period and duty are 0, and the output sits at the inactive level, which is the inverse of `pol_i`.
- R2: In edge-aligned mode (`center_i`=0) the count steps 0,1,…,P-1 on successive ticks and then returns to 0, where P is the working period. A working period of 0 behaves as a period of 1.
- R3: In center-aligned mode (`center_i`=1) the count steps 0 up to P-1, holds P-1 for one more tick, steps down to 0 and holds 0 for one more tick, giving 2P ticks per period.
- R4: While enabled, the output equals `pol_i` when the count is below the working duty and `!pol_i` otherwise. With `pol_i`=1 the high share of an edge-aligned period is D/P; with `pol_i`=0 it is (P-D)/P.
- R5: With P≥1, a working duty of P or more gives a constant active level, and a working duty of 0 gives a constant inactive level.
- R6: Writes to period or duty change only the holding registers. The working copies load from them on the tick that ends a period: the tick at count P-1 in edge-aligned mode, or the tick at count 0 in the falling half in center-aligned mode.
- R7: While `en_i` is 0, the count is forced to 0 and the direction to rising, the output is `!pol_i`, and the working copies load from the holding registers on every clock.
- R8: A pulse on `cnt_wr_i` clears the count to 0, sets the direction to rising and loads the working copies. It takes precedence over a tick in the same cycle.
- R9: The count and direction change only on clocks where `tick_i` is 1, `cnt_wr_i` is pulsed, or the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Channel clock enable; one count step per pulse |
| en_i | input | 1 | Channel enable |
| pol_i | input | 1 | Active level of the output |
| center_i | input | 1 | 1 selects center alignment, 0 edge alignment |
| per_wr_i | input | 1 | Write strobe for the period holding register |
| per_wdata_i | input | CNT_W | Period write data |
| duty_wr_i | input | 1 | Write strobe for the duty holding register |
| duty_wdata_i | input | CNT_W | Duty write data |
| cnt_wr_i | input | 1 | Counter write strobe; restarts the count |
| cnt_o | output | CNT_W | Current count |
| pwm_o | output | 1 | PWM output |

## Verification
The hardest case to reach is a write that lands partway through an enabled period. Only the working copies, which cannot be seen at the ports, show whether that write was held back. The stimulus rewrites period and duty mid-period in both alignments and at slowed tick rates. It also lands counter writes on the same clock as a tick and as a period write. A behavioural model tracks the position within the period and the holding and working values for each clock. The bench compares count and output against that model on every cycle, so a premature load appears as a wrong wrap point or pulse width.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             load_i,
  input  logic             per_wr_i,
  input  logic [CNT_W-1:0] per_wdata_i,
  input  logic             duty_wr_i,
  input  logic [CNT_W-1:0] duty_wdata_i,
  output logic [CNT_W-1:0] per_act_o,
  output logic [CNT_W-1:0] duty_act_o
);
  logic [CNT_W-1:0] per_hold_q;
  logic [CNT_W-1:0] duty_hold_q;
  logic             take_hold;

  assign take_hold = !en_i || load_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_hold_q  <= '0;
      duty_hold_q <= '0;
    end else begin
      if (per_wr_i)  per_hold_q  <= per_wdata_i;
      if (duty_wr_i) duty_hold_q <= duty_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_act_o  <= '0;
      duty_act_o <= '0;
    end else if (take_hold) begin
      per_act_o  <= per_hold_q;
      duty_act_o <= duty_hold_q;
    end
  end

  assert_act_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !load_i) |=> ($stable(per_act_o) && $stable(duty_act_o)));

  assert_idle_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> (per_act_o == $past(per_hold_q) && duty_act_o == $past(duty_hold_q)));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             center_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] per_act_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             period_end_o
);
  cnt_dir_e         dir_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_top;
  logic             at_floor;
  logic             step;

  function automatic logic [CNT_W-1:0] top_count(input logic [CNT_W-1:0] per);
    return (per == '0) ? '0 : per - 1'b1;
  endfunction

  assign at_top   = cnt_q >= top_count(per_act_i);
  assign at_floor = cnt_q == '0;
  assign step     = en_i && !cnt_wr_i && tick_i;

  assign period_end_o = step &&
    (center_i ? (dir_q == DIR_DOWN && at_floor) : at_top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (!en_i || cnt_wr_i) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (tick_i) begin
      if (!center_i) begin
        cnt_q <= at_top ? '0 : cnt_q + 1'b1;
      end else if (dir_q == DIR_UP) begin
        if (at_top) dir_q <= DIR_DOWN;
        else        cnt_q <= cnt_q + 1'b1;
      end else begin
        if (at_floor) dir_q <= DIR_UP;
        else          cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;

  assert_cnt_below_per_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && per_act_i != '0) |-> (cnt_q < per_act_i));

  assert_edge_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !center_i && at_top) |=> (cnt_q == '0));

  assert_center_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && center_i && dir_q == DIR_DOWN && !at_floor) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> (cnt_q == '0 && dir_q == DIR_UP));

  assert_cnt_wr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> (cnt_q == '0 && dir_q == DIR_UP));

  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_i && !cnt_wr_i) |=> ($stable(cnt_q) && $stable(dir_q)));
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int CNT_W = 8
) (
  input  logic             en_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_act_i,
  output logic             active_o,
  output logic             pwm_o
);
  function automatic logic in_active(input logic [CNT_W-1:0] c,
                                     input logic [CNT_W-1:0] d);
    return c < d;
  endfunction

  assign active_o = en_i && in_active(cnt_i, duty_act_i);
  assign pwm_o    = active_o ? pol_i : !pol_i;
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             pol_i,
  input  logic             center_i,
  input  logic             per_wr_i,
  input  logic [CNT_W-1:0] per_wdata_i,
  input  logic             duty_wr_i,
  input  logic [CNT_W-1:0] duty_wdata_i,
  input  logic             cnt_wr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] per_act;
  logic [CNT_W-1:0] duty_act;
  logic             period_end;
  logic             load_evt;
  logic             active;

  assign load_evt = period_end || cnt_wr_i;

  pwm_shadow_regs #(.CNT_W(CNT_W)) u_shadow (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .load_i       (load_evt),
    .per_wr_i     (per_wr_i),
    .per_wdata_i  (per_wdata_i),
    .duty_wr_i    (duty_wr_i),
    .duty_wdata_i (duty_wdata_i),
    .per_act_o    (per_act),
    .duty_act_o   (duty_act)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .tick_i       (tick_i),
    .center_i     (center_i),
    .cnt_wr_i     (cnt_wr_i),
    .per_act_i    (per_act),
    .cnt_o        (cnt_o),
    .period_end_o (period_end)
  );

  pwm_wave #(.CNT_W(CNT_W)) u_wave (
    .en_i       (en_i),
    .pol_i      (pol_i),
    .cnt_i      (cnt_o),
    .duty_act_i (duty_act),
    .active_o   (active),
    .pwm_o      (pwm_o)
  );

  assert_full_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && per_act != '0 && duty_act >= per_act) |-> (pwm_o == pol_i));

  assert_zero_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |-> (pwm_o == !pol_i));

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |-> (!active && pwm_o == !pol_i));
endmodule

// File: tb/pwm_chan_core_bench.sv
module pwm_chan_core_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         en = 1'b0;
  logic         pol = 1'b1;
  logic         center = 1'b0;
  logic         per_wr = 1'b0;
  logic [W-1:0] per_wd = '0;
  logic         duty_wr = 1'b0;
  logic [W-1:0] duty_wd = '0;
  logic         cnt_wr = 1'b0;
  logic [W-1:0] cnt;
  logic         pwm;

  int checks = 0;
  int errors = 0;
  int tick_n = 1;
  int tick_ctr = 0;
  bit done = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  // behavioural model state
  int pos = 0;
  int m_per = 0, m_duty = 0, b_per = 0, b_duty = 0;

  always #5 clk = ~clk;

  pwm_chan_core #(.CNT_W(W)) u_pwm_chan_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(en), .pol_i(pol),
    .center_i(center), .per_wr_i(per_wr), .per_wdata_i(per_wd),
    .duty_wr_i(duty_wr), .duty_wdata_i(duty_wd), .cnt_wr_i(cnt_wr),
    .cnt_o(cnt), .pwm_o(pwm)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_cnt();
    int pe;
    pe = (m_per == 0) ? 1 : m_per;
    if (!center) return pos;
    return (pos < pe) ? pos : 2 * pe - 1 - pos;
  endfunction

  function automatic int exp_pwm();
    if (!en) return !pol;
    return (exp_cnt() < m_duty) ? pol : !pol;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      pos = 0; m_per = 0; m_duty = 0; b_per = 0; b_duty = 0;
    end else begin
      if (!en || cnt_wr) begin
        pos = 0; m_per = b_per; m_duty = b_duty;
      end else if (tick) begin
        int pe, len;
        pe  = (m_per == 0) ? 1 : m_per;
        len = center ? 2 * pe : pe;
        if (pos == len - 1) begin
          pos = 0; m_per = b_per; m_duty = b_duty;
        end else begin
          pos = pos + 1;
        end
      end
      if (per_wr)  b_per  = per_wd;
      if (duty_wr) b_duty = duty_wd;
    end
    #2;
    if (cmp_on && rst_n) begin
      check(cur_req, cnt, exp_cnt(), "count");
      check(cur_req, pwm, exp_pwm(), "output");
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      tick = (tick_n <= 1) || ((tick_ctr % tick_n) == 0);
      tick_ctr++;
      @(negedge clk);
    end
  endtask

  task automatic wr_per(input int v);
    per_wr = 1'b1; per_wd = W'(v); cyc(1); per_wr = 1'b0;
  endtask

  task automatic wr_duty(input int v);
    duty_wr = 1'b1; duty_wd = W'(v); cyc(1); duty_wr = 1'b0;
  endtask

  task automatic wr_cnt();
    cnt_wr = 1'b1; cyc(1); cnt_wr = 1'b0;
  endtask

  task automatic high_share(input string req, input int span, input int exp);
    int highs;
    highs = 0;
    for (int i = 0; i < span; i++) begin
      if (pwm) highs++;
      cyc(1);
    end
    check(req, highs, exp, "high ticks per period");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", cnt, 0, "count after reset");
    check("R1", pwm, 0, "output after reset pol=1");
    pol = 1'b0; #1;
    check("R1", pwm, 1, "output after reset pol=0");
    pol = 1'b1;
    cmp_on = 1;

    // R2: edge-aligned counting
    cur_req = "R2";
    wr_per(10); wr_duty(3); cyc(2);
    en = 1'b1; cyc(40);
    // R4: high share with both polarities
    cur_req = "R4";
    wr_cnt(); high_share("R4", 10, 3);
    pol = 1'b0; wr_cnt(); high_share("R4", 10, 7);
    pol = 1'b1;
    // R9: slowed ticks
    cur_req = "R9"; tick_n = 3; cyc(60); tick_n = 1;
    // R6: mid-period writes held until boundary
    cur_req = "R6";
    cyc(4); wr_per(6); wr_duty(2); cyc(30);
    tick_n = 2; cyc(3); wr_per(12); cyc(50); tick_n = 1;
    // R5: full and zero duty
    cur_req = "R5";
    wr_duty(12); cyc(30);
    wr_duty(200); cyc(30);
    wr_duty(0); cyc(30);
    // R3: center alignment
    cur_req = "R3";
    en = 1'b0; center = 1'b1; wr_per(5); wr_duty(2); cyc(2);
    en = 1'b1; cyc(50);
    wr_cnt(); high_share("R3", 10, 4);
    tick_n = 2; cyc(40); wr_duty(4); cyc(40); tick_n = 1;
    cur_req = "R6"; cyc(3); wr_per(3); cyc(30);
    // R8: counter writes with ticks and period writes
    cur_req = "R8";
    cyc(4); wr_cnt(); cyc(7);
    per_wr = 1'b1; per_wd = 8'd7; cnt_wr = 1'b1; cyc(1); per_wr = 1'b0; cnt_wr = 1'b0;
    cyc(20); wr_cnt(); cyc(30);
    en = 1'b0; center = 1'b0; cyc(2); en = 1'b1; cyc(5); wr_cnt(); cyc(20);
    // R7: disable mid-run, rewrite while idle
    cur_req = "R7";
    cyc(3); en = 1'b0; cyc(5); wr_per(4); wr_duty(1); cyc(3);
    pol = 1'b0; cyc(4); en = 1'b1; cyc(20); pol = 1'b1;
    // R2: zero period and full-range period
    cur_req = "R2";
    en = 1'b0; wr_per(0); wr_duty(1); cyc(2); en = 1'b1; cyc(10);
    en = 1'b0; wr_per(255); wr_duty(128); cyc(2); en = 1'b1; cyc(600);
    cur_req = "R3";
    en = 1'b0; center = 1'b1; cyc(2); en = 1'b1; cyc(600);
    en = 1'b0; wr_per(0); cyc(2); en = 1'b1; cyc(10);

    cmp_on = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule